// File: doc/BRIEF.md
# Card Attribute-Space Configuration Register File

This block holds the configuration registers that a host reaches through the attribute memory space of a removable storage card running in ATA mode. It also produces the level of the host interrupt line. The host uses a byte-wide attribute bus with address, write data, write strobe, read strobe and registered read data. The address space splits at a parameterised base address. Below the base, reads are forwarded to a card-information ROM port, and the byte comes back when the address lies inside the ROM length. At and above the base there are four byte registers at even offsets: option, configuration status, pin replacement and socket/copy.

The drive's raw interrupt level enters the status register, where a high level means no request is pending. The host interrupt is raised only when that stored bit is low and interrupts are neither disabled nor held in reset by the device-control IEN and SRST bits. A write to the option register with its top bit set starts a card soft reset. A small control FSM tracks this reset. In state ST_RUN the card operates normally. The transition "soft-reset write" moves it to ST_RST, which drives the card reset pulse for one cycle. The transition "pulse done" returns it to ST_RUN. A further soft-reset write while in ST_RST keeps it in ST_RST.

Top module: `cfg_attr_regs`

## Requirements
- R1: After hardware reset the option register reads 0x00, configuration status reads 0x00, pin replacement reads 0x0C, the mode output is 0 and the card reset output is low.
- R2: A read below the base (default 0x200) returns the ROM byte for that address when the address is below the ROM length (default 330), and 0x00 otherwise. All read data appears on the cycle after the read strobe, and the ROM address output carries the low bits of the attribute address.
- R3: A write to the option register (base+0) stores the data ANDed with 0xCF. The mode output equals stored bits 5:0.
- R4: An option write with bit 7 set clears option, status and the pin ready flag, and drives card reset high for exactly the one cycle after the write. The option register then reads 0x00.
- R5: A status write (base+2) loads bits 6, 5, 4 and 2 (mask 0x74) from the data and leaves bit 7 and interrupt bit 1 untouched.
- R6: Status bit 1 follows the drive interrupt input sampled on each clock. A status read returns that bit forced to 0 while the device-control IEN input is high.
- R7: A status write whose bit 2 (power-down) differs from the stored bit 2 sets the pin ready flag. The flag stays set until a reset, and a write that keeps bit 2 unchanged does not set it.
- R8: A pin replacement read (base+4) returns 0x0C ORed with the ready flag at bit 5. A pin write does not change the ready flag.
- R9: The socket/copy register (base+6) and any other offset at or above the base read 0x00. Writes to them, and any write below the base, change no register.
- R10: The host interrupt output is a register. One clock after its inputs change it is high exactly when the drive interrupt input is low, IEN and SRST are low, and no soft-reset write is taking place. It is low during hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attr_addr | input | AW (12) | Attribute-space byte address |
| attr_wdata | input | 8 | Write data |
| attr_we | input | 1 | Write strobe, one cycle per write |
| attr_re | input | 1 | Read strobe, data returned next cycle |
| attr_rdata | output | 8 | Registered read data |
| rom_addr | output | RW (9) | Card-information ROM byte address |
| rom_data | input | 8 | Card-information ROM byte, combinational |
| drv_irq | input | 1 | Drive raw interrupt level, high = none pending |
| dctl_ien | input | 1 | Device-control interrupt-disable bit |
| dctl_srst | input | 1 | Device-control soft-reset bit |
| mode | output | 6 | Addressing mode field of the option register |
| host_irq | output | 1 | Host interrupt level |
| card_rst | output | 1 | One-cycle card reset pulse |

## Verification
The drive interrupt input and a host write to the status or option register can land on the same clock edge, and each of them updates the status byte. The bench raises the drive interrupt on the same edge as a status write of 0x70 and expects a later read of 0x72, because the interrupt bit comes from the input and the other bits come from the write data. It also applies a soft-reset write while the interrupt input is low and the device-control bits are clear. The host interrupt must then stay low during the pulse cycle and rise one cycle later.

// File: rtl/cfgregs_pkg.sv
package cfgregs_pkg;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_RST = 1'b1
    } card_state_e;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_ROM  = 3'd1,
        SEL_OPT  = 3'd2,
        SEL_STAT = 3'd3,
        SEL_PIN  = 3'd4,
        SEL_SOCK = 3'd5
    } attr_sel_e;

    // register offsets above the attribute base
    localparam int OFS_OPT  = 0;
    localparam int OFS_STAT = 2;
    localparam int OFS_PIN  = 4;
    localparam int OFS_SOCK = 6;

    localparam logic [7:0] PIN_FIXED   = 8'h0C;
    localparam logic [7:0] STAT_INT_M  = 8'h02;
    localparam int         OPT_SRST_B  = 7;
    localparam int         STAT_PD_B   = 2;
    localparam int         PIN_RDY_B   = 5;

endpackage

// File: rtl/attr_decode.sv
module attr_decode
    import cfgregs_pkg::*;
#(
    parameter int AW        = 12,
    parameter int ATTR_BASE = 'h200,
    parameter int ROM_LEN   = 330
) (
    input  logic [AW-1:0] addr,
    output attr_sel_e     sel
);
    localparam logic [AW-1:0] BASE_A = AW'(ATTR_BASE);
    localparam logic [AW-1:0] LEN_A  = AW'(ROM_LEN);

    logic [AW-1:0] ofs;

    always_comb begin
        ofs = addr - BASE_A;
        sel = SEL_NONE;
        if (addr < BASE_A) begin
            sel = (addr < LEN_A) ? SEL_ROM : SEL_NONE;
        end else begin
            case (ofs)
                AW'(OFS_OPT):  sel = SEL_OPT;
                AW'(OFS_STAT): sel = SEL_STAT;
                AW'(OFS_PIN):  sel = SEL_PIN;
                AW'(OFS_SOCK): sel = SEL_SOCK;
                default:       sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_state.sv
module cfg_state
    import cfgregs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_opt,
    input  logic       wr_stat,
    input  logic       sreset,
    input  logic [7:0] wdata,
    input  logic       drv_irq,
    output logic [7:0] opt_q,
    output logic [7:0] stat_q,
    output logic       rdy_q
);
    logic [3:0] mode_lo;
    logic       lvl_sel;
    logic [3:0] stat_w;    // stored bits 6,5,4,2
    logic       stat_int;
    logic       pd_flip;
    logic       unused_wbits;

    assign unused_wbits = &{1'b0, wdata[7], wdata[1]};
    assign pd_flip      = wdata[STAT_PD_B] ^ stat_w[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_lo  <= '0;
            lvl_sel  <= 1'b0;
            stat_w   <= '0;
            stat_int <= 1'b0;
            rdy_q    <= 1'b0;
        end else if (sreset) begin
            mode_lo  <= '0;
            lvl_sel  <= 1'b0;
            stat_w   <= '0;
            stat_int <= 1'b0;
            rdy_q    <= 1'b0;
        end else begin
            stat_int <= drv_irq;
            if (wr_opt) begin
                mode_lo <= wdata[3:0];
                lvl_sel <= wdata[6];
            end
            if (wr_stat) begin
                stat_w <= {wdata[6:4], wdata[STAT_PD_B]};
                if (pd_flip) rdy_q <= 1'b1;
            end
        end
    end

    assign opt_q  = {1'b0, lvl_sel, 2'b00, mode_lo};
    assign stat_q = {1'b0, stat_w[3:1], 1'b0, stat_w[0], stat_int, 1'b0};

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rdy_q) && !$past(sreset)) |-> rdy_q); // R7
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_stat) && !$past(sreset)) |-> $stable(stat_w)); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sreset) |-> (opt_q == 8'h00 && !rdy_q)); // R4

endmodule

// File: rtl/irq_gen.sv
module irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_irq,
    input  logic ien,
    input  logic srst,
    input  logic sreset,
    output logic host_irq
);
    logic irq_d;

    always_comb begin
        irq_d = !drv_irq && !ien && !srst && !sreset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_irq <= 1'b0;
        else        host_irq <= irq_d;
    end

    AST_IRQ_IEN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ien) |-> !host_irq); // R10
    AST_IRQ_ACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(drv_irq) |-> !host_irq); // R10

endmodule

// File: rtl/cfg_attr_regs.sv
module cfg_attr_regs
    import cfgregs_pkg::*;
#(
    parameter int AW        = 12,
    parameter int ATTR_BASE = 'h200,
    parameter int ROM_LEN   = 330,
    localparam int RW       = $clog2(ROM_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] attr_addr,
    input  logic [7:0]    attr_wdata,
    input  logic          attr_we,
    input  logic          attr_re,
    output logic [7:0]    attr_rdata,
    output logic [RW-1:0] rom_addr,
    input  logic [7:0]    rom_data,
    input  logic          drv_irq,
    input  logic          dctl_ien,
    input  logic          dctl_srst,
    output logic [5:0]    mode,
    output logic          host_irq,
    output logic          card_rst
);
    attr_sel_e   sel;
    card_state_e state_q, state_d;
    logic        wr_opt, wr_stat, sreset;
    logic [7:0]  opt_q, stat_q, rd_mux;
    logic        rdy_q;

    attr_decode #(.AW(AW), .ATTR_BASE(ATTR_BASE), .ROM_LEN(ROM_LEN)) dec_i (
        .addr (attr_addr),
        .sel  (sel)
    );

    assign wr_opt  = attr_we && (sel == SEL_OPT);
    assign wr_stat = attr_we && (sel == SEL_STAT);
    assign sreset  = wr_opt && attr_wdata[OPT_SRST_B];

    cfg_state st_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_opt  (wr_opt),
        .wr_stat (wr_stat),
        .sreset  (sreset),
        .wdata   (attr_wdata),
        .drv_irq (drv_irq),
        .opt_q   (opt_q),
        .stat_q  (stat_q),
        .rdy_q   (rdy_q)
    );

    irq_gen irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .drv_irq  (drv_irq),
        .ien      (dctl_ien),
        .srst     (dctl_srst),
        .sreset   (sreset),
        .host_irq (host_irq)
    );

    // soft-reset control FSM: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: if (sreset) state_d = ST_RST;
            ST_RST: state_d = sreset ? ST_RST : ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // FSM outputs
    always_comb begin
        card_rst = 1'b0;
        unique case (state_q)
            ST_RUN: card_rst = 1'b0;
            ST_RST: card_rst = 1'b1;
            default: card_rst = 1'b0;
        endcase
    end

    // read path
    assign rom_addr = attr_addr[RW-1:0];
    assign mode     = opt_q[5:0];

    always_comb begin
        rd_mux = 8'h00;
        case (sel)
            SEL_ROM:  rd_mux = rom_data;
            SEL_OPT:  rd_mux = opt_q;
            SEL_STAT: rd_mux = dctl_ien ? (stat_q & ~STAT_INT_M) : stat_q;
            SEL_PIN:  rd_mux = PIN_FIXED | (8'(rdy_q) << PIN_RDY_B);
            default:  rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       attr_rdata <= 8'h00;
        else if (attr_re) attr_rdata <= rd_mux;
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> $past(sreset)); // R4
    AST_SOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(attr_re && sel == SEL_SOCK) |-> (attr_rdata == 8'h00)); // R9
    AST_PIN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(attr_re && sel == SEL_PIN) |-> ((attr_rdata & 8'hDF) == PIN_FIXED)); // R8

endmodule

// File: tb/cfg_attr_regs_tb_top.sv
`timescale 1ns/1ps
module cfg_attr_regs_tb_top;
    localparam int AW = 12;
    localparam int RW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] attr_addr = '0;
    logic [7:0]    attr_wdata = '0;
    logic          attr_we = 1'b0, attr_re = 1'b0;
    logic [7:0]    attr_rdata;
    logic [RW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic          drv_irq = 1'b0, dctl_ien = 1'b0, dctl_srst = 1'b0;
    logic [5:0]    mode;
    logic          host_irq, card_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    assign rom_data = 8'(rom_addr) ^ 8'h5A;

    cfg_attr_regs dut_i (
        .clk(clk), .rst_n(rst_n), .attr_addr(attr_addr), .attr_wdata(attr_wdata),
        .attr_we(attr_we), .attr_re(attr_re), .attr_rdata(attr_rdata),
        .rom_addr(rom_addr), .rom_data(rom_data), .drv_irq(drv_irq),
        .dctl_ien(dctl_ien), .dctl_srst(dctl_srst), .mode(mode),
        .host_irq(host_irq), .card_rst(card_rst)
    );

    // {is_read, addr, wdata, expected, requirement}
    localparam int NV = 20;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 12'h000, 8'h00, 8'h5A, 4'd2},  // R2 first ROM byte
        {1'b1, 12'h011, 8'h00, 8'h4B, 4'd2},  // R2
        {1'b1, 12'h149, 8'h00, 8'h13, 4'd2},  // R2 last ROM byte
        {1'b1, 12'h14A, 8'h00, 8'h00, 4'd2},  // R2 past ROM length
        {1'b1, 12'h1FF, 8'h00, 8'h00, 4'd2},  // R2 just below base
        {1'b0, 12'h200, 8'h7F, 8'h00, 4'd3},  // R3 option write
        {1'b1, 12'h200, 8'h00, 8'h4F, 4'd3},  // R3 masked by 0xCF
        {1'b0, 12'h202, 8'hFF, 8'h00, 4'd5},  // R5 status write
        {1'b1, 12'h202, 8'h00, 8'h74, 4'd5},  // R5
        {1'b1, 12'h204, 8'h00, 8'h2C, 4'd7},  // R7 PD flipped -> ready
        {1'b0, 12'h204, 8'h00, 8'h00, 4'd8},  // R8 pin write
        {1'b1, 12'h204, 8'h00, 8'h2C, 4'd8},  // R8 ready kept
        {1'b0, 12'h202, 8'h04, 8'h00, 4'd5},  // R5
        {1'b1, 12'h202, 8'h00, 8'h04, 4'd5},  // R5
        {1'b0, 12'h206, 8'hFF, 8'h00, 4'd9},  // R9 socket write
        {1'b1, 12'h206, 8'h00, 8'h00, 4'd9},  // R9 socket reads 0
        {1'b1, 12'h203, 8'h00, 8'h00, 4'd9},  // R9 odd offset
        {1'b0, 12'h100, 8'hAA, 8'h00, 4'd9},  // R9 write below base
        {1'b1, 12'h200, 8'h00, 8'h4F, 4'd9},  // R9 option untouched
        {1'b1, 12'h202, 8'h00, 8'h04, 4'd9}   // R9 status untouched
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        attr_addr = a; attr_wdata = d; attr_we = 1'b1;
        @(negedge clk);
        attr_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        attr_addr = a; attr_re = 1'b1;
        @(negedge clk);
        attr_re = 1'b0;
        d = attr_rdata;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin : stim
        logic [7:0] d;
        repeat (3) @(negedge clk);
        check(8'(card_rst), 8'h0, "R1 card_rst in reset");
        check(8'(host_irq), 8'h0, "R10 irq in reset");
        rst_n = 1'b1;
        @(negedge clk);
        dctl_ien = 1'b1;
        check(8'(mode), 8'h00, "R1 mode");
        rd(12'h200, d); check(d, 8'h00, "R1 option");
        rd(12'h202, d); check(d, 8'h00, "R1 status");
        rd(12'h204, d); check(d, 8'h0C, "R1 pin");
        dctl_ien = 1'b0;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][32]) begin
                rd(VEC[i][31:20], d);
                check(d, VEC[i][11:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
            end else begin
                wr(VEC[i][31:20], VEC[i][19:12]);
            end
        end

        // R10 interrupt level and latency
        check(8'(host_irq), 8'h1, "R10 idle asserted");
        drv_irq = 1'b1;
        #1 check(8'(host_irq), 8'h1, "R10 before edge");
        @(negedge clk);
        check(8'(host_irq), 8'h0, "R10 drive high clears");
        rd(12'h202, d); check(d, 8'h06, "R6 interrupt bit");
        dctl_ien = 1'b1;
        rd(12'h202, d); check(d, 8'h04, "R6 hidden under IEN");
        drv_irq = 1'b0;
        @(negedge clk);
        check(8'(host_irq), 8'h0, "R10 IEN masks");
        dctl_ien = 1'b0; dctl_srst = 1'b1;
        @(negedge clk);
        check(8'(host_irq), 8'h0, "R10 SRST masks");
        dctl_srst = 1'b0;
        @(negedge clk);
        check(8'(host_irq), 8'h1, "R10 reasserts");

        // R3 mode output
        check(8'(mode), 8'h0F, "R3 mode after 0x7F");
        wr(12'h200, 8'h01);
        check(8'(mode), 8'h01, "R3 mode 1");

        // R4 soft reset
        wr(12'h200, 8'h80);
        check(8'(card_rst), 8'h1, "R4 pulse high");
        check(8'(host_irq), 8'h0, "R10 low during soft reset");
        @(negedge clk);
        check(8'(card_rst), 8'h0, "R4 pulse one cycle");
        check(8'(host_irq), 8'h1, "R10 back after soft reset");
        check(8'(mode), 8'h00, "R4 mode cleared");
        rd(12'h200, d); check(d, 8'h00, "R4 option cleared");
        rd(12'h202, d); check(d, 8'h00, "R4 status cleared");
        rd(12'h204, d); check(d, 8'h0C, "R4 ready cleared");

        // R7 ready flag only on power-down change
        wr(12'h202, 8'h00);
        rd(12'h204, d); check(d, 8'h0C, "R7 no change no flag");
        wr(12'h202, 8'h04);
        rd(12'h204, d); check(d, 8'h2C, "R7 flip sets flag");
        wr(12'h202, 8'h00);
        rd(12'h204, d); check(d, 8'h2C, "R7 flag sticky");

        // same-edge status write and drive interrupt change
        drv_irq = 1'b1;
        wr(12'h202, 8'h70);
        check(8'(host_irq), 8'h0, "R10 same edge");
        rd(12'h202, d); check(d, 8'h72, "R5 R6 same edge");
        drv_irq = 1'b0;

        // R1 hardware reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h202, d); check(d, 8'h00, "R1 status after reset");
        rd(12'h204, d); check(d, 8'h0C, "R1 pin after reset");

        done = 1'b1;
        finish_run();
    end

endmodule